// File: doc/BRIEF.md
# Flash Array Access and Protection Guard

This block sits between a bus interface and an on-chip flash array that is split into equal array blocks. It holds two per-block masks. The data-space-only mask marks blocks that may be read by data accesses but not by instruction fetches. The protect mask marks blocks whose program and erase voltages must never be switched on. A control word can also enable one small region, with a fixed base and size, inside one array block. While that region is enabled, its own data-space and protect bits replace the bits of the block that contains it. The rest of that block still uses the block's own bits.

Every bus access is decoded in the same cycle it is presented. If the access is an instruction fetch and the selected region is data-only, the block raises an error together with the strobe and withholds the read-valid indication. Valid accesses pass through with no added latency. A program or erase request starts a sequence of fixed length. The high-voltage enable is driven only if the addressed region was unprotected when the request was accepted. The completion flag is raised in every case, so a protected sequence still goes through all of its steps and simply never applies voltage. Register writes take effect only while the write-unlock input is 1 and the configuration-state input is 0.

Top module: `flash_guard`

## Requirements
- R1: After reset the data-space mask reads 8'h00, the protect mask reads 8'hFF, and the small-region control word reads 8'h04. The control word layout is bit0 = region enable, bit1 = region data-only, bit2 = region protect, and bits 7:3 always read as 0.
- R2: A register write changes state only when `cfg_en`=1, `wr_unlock`=1 and `cfg_state`=0. Any other write leaves all three registers unchanged.
- R3: `cfg_rdata` returns the register chosen by `cfg_sel` (0 = data-space mask, 1 = protect mask, 2 = control word, 3 = reads as zero) whenever `cfg_en`=1, and is 0 when `cfg_en`=0.
- R4: The array block index is the top log2(N_BLK) address bits. Bit k of each mask belongs to block k.
- R5: When `acc_vld`=1, `acc_fetch`=1 and the governing data-space bit is 1, `acc_err` is 1 in that same cycle and `rd_vld` is 0. A data access (`acc_fetch`=0) never raises `acc_err`.
- R6: When `acc_vld`=1 and the access is allowed, `rd_vld` is 1 in the same cycle. When `acc_vld`=0, both `rd_vld` and `acc_err` are 0.
- R7: When the region enable bit is 1, addresses in [SB_BASE, SB_BASE+SB_SIZE) are governed by the control word's data-only and protect bits. Every other address, and every address when the enable is 0, is governed by its block's mask bits.
- R8: From an accepted `op_req`, `op_busy` is high for exactly PE_CYCLES cycles and `op_done` pulses for one cycle right after. This holds whether or not the region is protected.
- R9: `hv_en` is 1 during a sequence exactly when the governing protect bit of `op_addr` was 0 at acceptance. It is 0 outside a sequence.
- R10: An `op_req` that arrives while `op_busy`=1 is ignored. It changes neither the length of the running sequence nor `hv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Register access enable |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| wr_unlock | input | 1 | Write permitted when 1 |
| cfg_state | input | 1 | Writes blocked when 1 |
| cfg_rdata | output | 8 | Register read data |
| acc_vld | input | 1 | Bus access strobe |
| acc_addr | input | ADDR_W | Bus access address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_err | output | 1 | Access violates data-space rule |
| rd_vld | output | 1 | Access allowed, read data valid |
| op_req | input | 1 | Program/erase start request |
| op_addr | input | ADDR_W | Program/erase target address |
| op_busy | output | 1 | Sequence in progress |
| hv_en | output | 1 | Program/erase voltage enable |
| op_done | output | 1 | Sequence completion pulse |

## Verification
The assertions assume that `cfg_wdata`, `cfg_sel` and the gating inputs are stable around each clock edge. They also assume that an access is judged only in a cycle where `acc_vld` is high. The bench changes every input on the falling edge and reads results just before the next rising edge. It sweeps every address in both spaces under several mask and control-word settings. Sequences are started only from the idle state, except when the bench deliberately checks that a request arriving during a sequence is ignored.

// File: rtl/fgd_pkg.sv
// Package: shared selector encoding and control-word field positions for
// the flash guard. Assumes an 8-bit register data path.
package fgd_pkg;
    typedef enum logic [1:0] {
        SEL_DSPACE = 2'd0,
        SEL_PROT   = 2'd1,
        SEL_SBCTL  = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    localparam int SBCTL_EN   = 0;
    localparam int SBCTL_DATA = 1;
    localparam int SBCTL_PROT = 2;

    typedef struct packed {
        logic prot;
        logic data_only;
        logic en;
    } sbctl_t;
endpackage

// File: rtl/fgd_cfg_regs.sv
// Configuration registers: data-space mask, protect mask, small-region
// control word. Writes are accepted only when enabled, unlocked and not in
// configuration state. Assumes N_BLK <= 8 so masks fit the 8-bit data path.
module fgd_cfg_regs
    import fgd_pkg::*;
#(
    parameter int N_BLK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             wr_unlock,
    input  logic             cfg_state,
    output logic [7:0]       cfg_rdata,
    output logic [N_BLK-1:0] dmask,
    output logic [N_BLK-1:0] pmask,
    output sbctl_t           sbctl
);
    logic wr_ok;

    // Qualify a write by enable, unlock and configuration state.
    assign wr_ok = cfg_en && cfg_wr && wr_unlock && !cfg_state;

    // Register state with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmask <= '0;
            pmask <= '1;
            sbctl <= '{prot: 1'b1, data_only: 1'b0, en: 1'b0};
        end else if (wr_ok) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_DSPACE: dmask <= cfg_wdata[N_BLK-1:0];
                SEL_PROT:   pmask <= cfg_wdata[N_BLK-1:0];
                SEL_SBCTL: begin
                    sbctl.en        <= cfg_wdata[SBCTL_EN];
                    sbctl.data_only <= cfg_wdata[SBCTL_DATA];
                    sbctl.prot      <= cfg_wdata[SBCTL_PROT];
                end
                default: ;
            endcase
        end
    end

    // Readback multiplexer, zero while registers are disabled.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_en) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_DSPACE: cfg_rdata[N_BLK-1:0] = dmask;
                SEL_PROT:   cfg_rdata[N_BLK-1:0] = pmask;
                SEL_SBCTL: begin
                    cfg_rdata[SBCTL_EN]   = sbctl.en;
                    cfg_rdata[SBCTL_DATA] = sbctl.data_only;
                    cfg_rdata[SBCTL_PROT] = sbctl.prot;
                end
                default: cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fgd_region_decode.sv
// Region decode: maps an address to its governing data-only and protect
// bits, letting the enabled small region override its parent block.
// Assumes N_BLK is a power of two and the small region lies inside the space.
module fgd_region_decode
    import fgd_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int N_BLK   = 8,
    parameter int SB_BASE = 512,
    parameter int SB_SIZE = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_BLK-1:0]  dmask,
    input  logic [N_BLK-1:0]  pmask,
    input  sbctl_t            sbctl,
    output logic              data_only,
    output logic              prot
);
    localparam int BIDX_W = (N_BLK > 1) ? $clog2(N_BLK) : 1;
    localparam int SB_END = SB_BASE + SB_SIZE;

    logic [BIDX_W-1:0] blk;
    logic              in_sb;

    // Block index from the upper address bits.
    assign blk = addr[ADDR_W-1 -: BIDX_W];

    // Small-region window test, widened to avoid wrap at the top.
    always_comb begin
        in_sb = sbctl.en
             && ({1'b0, addr} >= (ADDR_W+1)'(SB_BASE))
             && ({1'b0, addr} <  (ADDR_W+1)'(SB_END));
    end

    // Select governing bits.
    always_comb begin
        if (in_sb) begin
            data_only = sbctl.data_only;
            prot      = sbctl.prot;
        end else begin
            data_only = dmask[blk];
            prot      = pmask[blk];
        end
    end
endmodule

// File: rtl/fgd_pe_seq.sv
// Program/erase sequencer: fixed-length sequence per accepted request.
// The protect decision is captured at acceptance; voltage enable is
// withheld for protected regions but completion is still signalled.
module fgd_pe_seq #(
    parameter int PE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_req,
    input  logic prot_in,
    output logic op_busy,
    output logic hv_en,
    output logic op_done
);
    localparam int CNT_W = $clog2(PE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             prot_q;

    // Sequence state: start, count down, finish with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            op_busy <= 1'b0;
            op_done <= 1'b0;
            prot_q  <= 1'b1;
        end else begin
            op_done <= 1'b0;
            if (!op_busy) begin
                if (op_req) begin
                    op_busy <= 1'b1;
                    cnt     <= CNT_W'(PE_CYCLES);
                    prot_q  <= prot_in;
                end
            end else if (cnt == CNT_W'(1)) begin
                op_busy <= 1'b0;
                op_done <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Voltage enable only inside an unprotected sequence.
    assign hv_en = op_busy && !prot_q;
endmodule

// File: rtl/flash_guard.sv
// Top: flash access guard. Combinational access check (no added latency)
// and a program/erase sequencer, both fed by the shared configuration
// registers. Assumes synchronous active-low reset.
module flash_guard
    import fgd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int N_BLK     = 8,
    parameter int SB_BASE   = 512,
    parameter int SB_SIZE   = 64,
    parameter int PE_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              wr_unlock,
    input  logic              cfg_state,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_fetch,
    output logic              acc_err,
    output logic              rd_vld,
    input  logic              op_req,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              op_busy,
    output logic              hv_en,
    output logic              op_done
);
    logic [N_BLK-1:0] dmask_q;
    logic [N_BLK-1:0] pmask_q;
    sbctl_t           sbctl_q;
    logic             acc_donly;
    logic             acc_prot_unused;
    logic             op_donly_unused;
    logic             op_prot;
    logic             unused_ok;

    fgd_cfg_regs #(.N_BLK(N_BLK)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .wr_unlock(wr_unlock),
        .cfg_state(cfg_state), .cfg_rdata(cfg_rdata),
        .dmask(dmask_q), .pmask(pmask_q), .sbctl(sbctl_q)
    );

    fgd_region_decode #(.ADDR_W(ADDR_W), .N_BLK(N_BLK),
                        .SB_BASE(SB_BASE), .SB_SIZE(SB_SIZE)) u_acc_dec (
        .addr(acc_addr), .dmask(dmask_q), .pmask(pmask_q), .sbctl(sbctl_q),
        .data_only(acc_donly), .prot(acc_prot_unused)
    );

    fgd_region_decode #(.ADDR_W(ADDR_W), .N_BLK(N_BLK),
                        .SB_BASE(SB_BASE), .SB_SIZE(SB_SIZE)) u_op_dec (
        .addr(op_addr), .dmask(dmask_q), .pmask(pmask_q), .sbctl(sbctl_q),
        .data_only(op_donly_unused), .prot(op_prot)
    );

    fgd_pe_seq #(.PE_CYCLES(PE_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .prot_in(op_prot),
        .op_busy(op_busy), .hv_en(hv_en), .op_done(op_done)
    );

    // Same-cycle space check on each access strobe.
    always_comb begin
        acc_err = acc_vld && acc_fetch && acc_donly;
        rd_vld  = acc_vld && !acc_err;
    end

    // Decoder outputs not needed on each path.
    assign unused_ok = &{1'b0, acc_prot_unused, op_donly_unused};
endmodule

// File: rtl/fgd_checker.sv
// Checker for flash_guard, attached by bind.
module fgd_checker #(
    parameter int N_BLK = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_unlock,
    input logic             cfg_state,
    input logic             cfg_en,
    input logic             acc_vld,
    input logic             acc_fetch,
    input logic             acc_err,
    input logic             rd_vld,
    input logic             op_busy,
    input logic             hv_en,
    input logic             op_done,
    input logic [N_BLK-1:0] dmask,
    input logic [N_BLK-1:0] pmask
);
    // R2
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_unlock || cfg_state || !cfg_en) |=> ($stable(dmask) && $stable(pmask)));
    // R5
    fetch_only_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_vld && acc_fetch && !rd_vld));
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |-> (!acc_err && !rd_vld));
    // R6
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> (acc_err != rd_vld));
    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy && !$past(op_busy) |-> !op_done);
    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(op_busy) |-> op_done);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    // R9
    hv_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> op_busy);
    // R10
    hv_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |=> (op_busy |-> $stable(hv_en)));
endmodule

bind flash_guard fgd_checker #(.N_BLK(N_BLK)) u_fgd_chk (
    .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .cfg_state(cfg_state),
    .cfg_en(cfg_en), .acc_vld(acc_vld), .acc_fetch(acc_fetch),
    .acc_err(acc_err), .rd_vld(rd_vld), .op_busy(op_busy), .hv_en(hv_en),
    .op_done(op_done), .dmask(dmask_q), .pmask(pmask_q)
);

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
    localparam int AW = 12;
    localparam int SBB = 512;
    localparam int SBS = 64;
    localparam int PEC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_wr = 1'b0, wr_unlock = 1'b0, cfg_state = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic acc_vld = 1'b0, acc_fetch = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic acc_err, rd_vld;
    logic op_req = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic op_busy, hv_en, op_done;

    int vecs = 0;
    int errs = 0;
    logic [7:0] m_d, m_p, m_c;

    always #2 clk = ~clk;

    flash_guard #(.ADDR_W(AW), .N_BLK(8), .SB_BASE(SBB), .SB_SIZE(SBS),
                  .PE_CYCLES(PEC)) u_flash_guard (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .wr_unlock(wr_unlock),
        .cfg_state(cfg_state), .cfg_rdata(cfg_rdata), .acc_vld(acc_vld),
        .acc_addr(acc_addr), .acc_fetch(acc_fetch), .acc_err(acc_err),
        .rd_vld(rd_vld), .op_req(op_req), .op_addr(op_addr),
        .op_busy(op_busy), .hv_en(hv_en), .op_done(op_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic gov(input logic [AW-1:0] a, input logic want_prot);
        logic in_sb;
        in_sb = m_c[0] && (int'(a) >= SBB) && (int'(a) < SBB + SBS);
        if (in_sb) return want_prot ? m_c[2] : m_c[1];
        return want_prot ? m_p[a[AW-1 -: 3]] : m_d[a[AW-1 -: 3]];
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d,
                      input logic en, input logic unl, input logic cst);
        @(negedge clk);
        cfg_en = en; cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        wr_unlock = unl; cfg_state = cst;
        @(negedge clk);
        cfg_wr = 1'b0; wr_unlock = 1'b0; cfg_state = 1'b0;
        if (en && unl && !cst) begin
            if (sel == 2'd0) m_d = d;
            else if (sel == 2'd1) m_p = d;
            else if (sel == 2'd2) m_c = d & 8'h07;
        end
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic en);
        logic [7:0] e;
        cfg_en = en; cfg_sel = sel;
        #1;
        e = !en ? 8'h00 : (sel == 2'd0) ? m_d : (sel == 2'd1) ? m_p :
            (sel == 2'd2) ? m_c : 8'h00;
        chk(req, 32'(cfg_rdata), 32'(e));
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < (1 << AW); a++) begin
            for (int f = 0; f < 2; f++) begin
                logic e_err;
                @(negedge clk);
                acc_vld = 1'b1; acc_addr = AW'(a); acc_fetch = f[0];
                #1;
                e_err = f[0] && gov(AW'(a), 1'b0);
                chk({tag, " R5 err"}, 32'(acc_err), 32'(e_err));
                chk({tag, " R6 rdvld"}, 32'(rd_vld), 32'(!e_err));
            end
        end
        @(negedge clk);
        acc_vld = 1'b0; acc_fetch = 1'b1;
        #1;
        chk("R6 idle", 32'({acc_err, rd_vld}), 32'h0);
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic poke);
        logic e_hv;
        @(negedge clk);
        op_req = 1'b1; op_addr = a;
        e_hv = !gov(a, 1'b1);
        @(negedge clk);
        op_req = 1'b0;
        for (int c = 0; c < PEC; c++) begin
            chk("R8 busy", 32'(op_busy), 32'h1);
            chk("R9 hv", 32'(hv_en), 32'(e_hv));
            chk("R8 nodone", 32'(op_done), 32'h0);
            if (poke && c == 1) begin
                op_req = 1'b1; op_addr = a ^ 12'h800;
            end else begin
                op_req = 1'b0;
            end
            @(negedge clk);
        end
        op_req = 1'b0;
        chk("R8 done", 32'({op_busy, op_done}), 32'h1);
        chk("R9 hv off", 32'(hv_en), 32'h0);
        @(negedge clk);
        chk("R8 done pulse", 32'(op_done), 32'h0);
        chk("R10 no restart", 32'(op_busy), 32'h0);
    endtask

    initial begin
        m_d = 8'h00; m_p = 8'hFF; m_c = 8'h04;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values, R3 readback
        for (int s = 0; s < 4; s++) rd_chk("R1 reset", 2'(s), 1'b1);
        rd_chk("R3 disabled", 2'd1, 1'b0);
        // R2 blocked writes
        wr(2'd0, 8'h3C, 1'b1, 1'b0, 1'b0);
        rd_chk("R2 locked", 2'd0, 1'b1);
        wr(2'd1, 8'h00, 1'b1, 1'b1, 1'b1);
        rd_chk("R2 cfgstate", 2'd1, 1'b1);
        wr(2'd2, 8'h01, 1'b0, 1'b1, 1'b0);
        rd_chk("R2 disabled", 2'd2, 1'b1);
        wr(2'd3, 8'hFF, 1'b1, 1'b1, 1'b0);
        rd_chk("R3 sel3", 2'd3, 1'b1);
        rd_chk("R2 sel3 side", 2'd0, 1'b1);
        // R9 all protected at reset
        run_op(12'h000, 1'b0);
        // R4 R5 R6 config A, no small region
        wr(2'd0, 8'hA5, 1'b1, 1'b1, 1'b0);
        wr(2'd1, 8'h5A, 1'b1, 1'b1, 1'b0);
        rd_chk("R3 dmask", 2'd0, 1'b1);
        rd_chk("R3 pmask", 2'd1, 1'b1);
        sweep("cfgA");
        // R7 small region data-only inside data/instr block 1
        wr(2'd0, 8'h01, 1'b1, 1'b1, 1'b0);
        wr(2'd2, 8'hFB, 1'b1, 1'b1, 1'b0);
        rd_chk("R1 sbctl bits", 2'd2, 1'b1);
        sweep("cfgB R7");
        // R7 small region open inside data-only block 1
        wr(2'd0, 8'hFE, 1'b1, 1'b1, 1'b0);
        wr(2'd2, 8'h01, 1'b1, 1'b1, 1'b0);
        sweep("cfgC R7");
        // R7 region disabled but bits set: block bits govern
        wr(2'd2, 8'h02, 1'b1, 1'b1, 1'b0);
        sweep("cfgD R7");
        // R9 ops across regions, region enabled and unprotected
        wr(2'd1, 8'hFD, 1'b1, 1'b1, 1'b0);
        wr(2'd2, 8'h01, 1'b1, 1'b1, 1'b0);
        run_op(12'h200, 1'b0);
        run_op(12'h23F, 1'b0);
        run_op(12'h240, 1'b0);
        run_op(12'h1FF, 1'b0);
        wr(2'd2, 8'h05, 1'b1, 1'b1, 1'b0);
        wr(2'd1, 8'h02, 1'b1, 1'b1, 1'b0);
        run_op(12'h210, 1'b0);
        run_op(12'h260, 1'b0);
        run_op(12'hE00, 1'b0);
        // R10 request during a sequence
        run_op(12'h260, 1'b1);
        run_op(12'h210, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule